// File: doc/BRIEF.md
# Decrementer timer with auto-reload

This block is the down-counting decrementer of a processor timer unit. Each cycle in which the time-base tick input is high, it lowers its count by one. When a tick carries the count from one to zero, it records the event in a sticky status flag. The interrupt line is high while that flag is set and the interrupt enable bit of the control register is also set.

Software reaches four registers through one write port and one read port: the count, a reload value, a control word and a status word. When the auto-reload control bit is set, a zero event loads the count from the reload register at once, so the timer runs as a periodic source. When the bit is clear, the count parks at zero and raises only one event. Software clears the status flag by writing a one to its bit.

Top module: `dec_timer`

## Requirements
- R1: After reset the count, reload, control and status registers all read 0 and `irq` is low.
- R2: When `tick_en` is low and no count write occurs, the count keeps its value.
- R3: When `tick_en` is high and the count is above 1, the count drops by exactly 1 per cycle.
- R4: A tick at count 1 is a zero event. It sets status bit 27, so the status reads 0x08000000. With auto-reload off the count then stays at 0, and later ticks raise no new event.
- R5: With control bit 22 (auto-reload) set, a zero event loads the count from the reload register in the same edge, and each later expiry sets the flag again.
- R6: A status write (select 3) clears each implemented bit written as 1 and leaves bits written as 0 unchanged. A zero event in the same cycle as a clear leaves the flag set.
- R7: `irq` equals status bit 27 AND control bit 26 (interrupt enable). It follows a control or status write from the next cycle on.
- R8: A count write (select 0) in a cycle with an active tick loads the written value, and that tick does not decrement it.
- R9: Register selects are 0 count, 1 reload, 2 control and 3 status. Reload and control read back as written. Status reads only bit 27, and all other status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Time-base tick; the count moves only when high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write register select (0 count, 1 reload, 2 control, 3 status) |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read register select, same encoding |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Decrementer interrupt request |

## Verification
The count path is driven with ticks held low, with ticks held high through a run down to zero, with ticks continuing after zero, and with a count write that collides with a tick. These cases separate holding, decrementing, parking at zero and write priority. The auto-reload runs span two full periods, which shows that the reload repeats rather than firing once. Status writes use a mask with bit 27 cleared, a mask with bit 27 set, and a clear that lands in the same cycle as an expiry. Together these show the write-one-to-clear behaviour and which side wins a collision. The interrupt is observed while the enable and the flag are each toggled on their own, which confirms the AND gating.

// File: rtl/dec_timer.sv
module dec_timer #(
  parameter int W        = 32,
  parameter int EN_BIT   = 26,
  parameter int ARE_BIT  = 22,
  parameter int FLAG_BIT = 27
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_sel,
  output logic [W-1:0] rd_data,
  output logic         irq
);
  localparam logic [1:0] SEL_CNT = 2'd0;
  localparam logic [1:0] SEL_RLD = 2'd1;
  localparam logic [1:0] SEL_CTL = 2'd2;
  localparam logic [1:0] SEL_STS = 2'd3;

  logic [W-1:0] cnt_q, rld_q, ctl_q;
  logic         flag_q;

  wire wr_cnt = wr_en && (wr_sel == SEL_CNT);
  wire wr_rld = wr_en && (wr_sel == SEL_RLD);
  wire wr_ctl = wr_en && (wr_sel == SEL_CTL);
  wire wr_sts = wr_en && (wr_sel == SEL_STS);
  wire step   = tick_en && !wr_cnt && (cnt_q != '0);
  wire hit    = step && (cnt_q == W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      ctl_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_cnt)     cnt_q <= wr_data;
      else if (hit)   cnt_q <= ctl_q[ARE_BIT] ? rld_q : '0;
      else if (step)  cnt_q <= cnt_q - W'(1);
      if (wr_rld) rld_q <= wr_data;
      if (wr_ctl) ctl_q <= wr_data;
      if (hit)                               flag_q <= 1'b1;
      else if (wr_sts && wr_data[FLAG_BIT])  flag_q <= 1'b0;
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_CNT: rd_data = cnt_q;
      SEL_RLD: rd_data = rld_q;
      SEL_CTL: rd_data = ctl_q;
      default: rd_data = W'(flag_q) << FLAG_BIT;
    endcase
  end

  assign irq = flag_q & ctl_q[EN_BIT];

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_cnt) |=> $stable(cnt_q));
  p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !wr_cnt && cnt_q > W'(1)) |=> (cnt_q == $past(cnt_q) - W'(1)));
  p_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !wr_cnt && cnt_q == W'(1)) |=> flag_q);
  p_park_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && cnt_q == '0) |=> (cnt_q == '0 && $stable(flag_q) || !flag_q));
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !wr_cnt && cnt_q == W'(1) && ctl_q[ARE_BIT]) |=> (cnt_q == $past(rld_q)));
  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && wr_data[FLAG_BIT] && !(tick_en && !wr_cnt && cnt_q == W'(1))) |=> !flag_q);
  p_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rd_sel != SEL_STS || rd_data[FLAG_BIT]));
  p_wrprio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt_q == $past(wr_data)));
endmodule

// File: tb/dec_timer_test.sv
module dec_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] FLAG = 32'h0800_0000;
  localparam logic [31:0] IEN  = 32'h0400_0000;
  localparam logic [31:0] ARE  = 32'h0040_0000;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0, rd_sel = 2'd0;
  logic [31:0] wr_data = '0, rd_data;
  logic irq;
  int n_chk = 0, n_bad = 0;

  dec_timer uut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] s, output logic [31:0] v);
    rd_sel = s; #1; v = rd_data;
  endtask

  task automatic expect_reg(string req, logic [1:0] s, logic [31:0] e);
    logic [31:0] v;
    rd(s, v); check(req, v, e);
  endtask

  task automatic t_reset;
    for (int s = 0; s < 4; s++) expect_reg("R1 reset reg", 2'(s), 32'h0);
    check("R1 reset irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_hold;
    wr(2'd0, 32'd10);
    tick_en = 1'b0; cyc(5);
    expect_reg("R2 hold without tick", 2'd0, 32'd10);
  endtask

  task automatic t_count;
    tick_en = 1'b1; cyc(3); tick_en = 1'b0;
    expect_reg("R3 decrement", 2'd0, 32'd7);
  endtask

  task automatic t_zero;
    wr(2'd2, 32'h0);
    wr(2'd0, 32'd3);
    tick_en = 1'b1; cyc(2);
    expect_reg("R4 no flag before zero", 2'd3, 32'h0);
    cyc(1);
    expect_reg("R4 count at zero", 2'd0, 32'd0);
    expect_reg("R4 flag set", 2'd3, FLAG);
    check("R7 irq masked", {31'h0, irq}, 32'h0);
    cyc(5);
    expect_reg("R4 parked at zero", 2'd0, 32'd0);
    tick_en = 1'b0;
    wr(2'd3, FLAG);
    tick_en = 1'b1; cyc(4); tick_en = 1'b0;
    expect_reg("R4 no second event", 2'd3, 32'h0);
  endtask

  task automatic t_irq;
    wr(2'd0, 32'd1);
    tick_en = 1'b1; cyc(); tick_en = 1'b0;
    check("R7 irq off, enable clear", {31'h0, irq}, 32'h0);
    wr(2'd2, IEN);
    check("R7 irq after enable", {31'h0, irq}, 32'h1);
    wr(2'd2, 32'h0);
    check("R7 irq after disable", {31'h0, irq}, 32'h0);
    wr(2'd2, IEN);
    wr(2'd3, 32'h0);
    check("R7 irq kept by zero write", {31'h0, irq}, 32'h1);
    wr(2'd3, FLAG);
    check("R7 irq after clear", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_w1c;
    wr(2'd0, 32'd1);
    tick_en = 1'b1; cyc(); tick_en = 1'b0;
    wr(2'd3, ~FLAG);
    expect_reg("R6 zero bit keeps flag", 2'd3, FLAG);
    wr(2'd3, 32'hFFFF_FFFF);
    expect_reg("R6 one bit clears flag", 2'd3, 32'h0);
    wr(2'd0, 32'd1);
    tick_en = 1'b1; wr(2'd3, FLAG); tick_en = 1'b0;
    expect_reg("R6 event beats clear", 2'd3, FLAG);
    wr(2'd3, FLAG);
  endtask

  task automatic t_reload;
    wr(2'd1, 32'd4);
    wr(2'd2, ARE | IEN);
    wr(2'd0, 32'd2);
    tick_en = 1'b1; cyc(2); tick_en = 1'b0;
    expect_reg("R5 reloaded", 2'd0, 32'd4);
    expect_reg("R5 flag on reload", 2'd3, FLAG);
    check("R5 irq on reload", {31'h0, irq}, 32'h1);
    wr(2'd3, FLAG);
    tick_en = 1'b1; cyc(3); tick_en = 1'b0;
    expect_reg("R5 second period running", 2'd0, 32'd1);
    expect_reg("R5 no early flag", 2'd3, 32'h0);
    tick_en = 1'b1; cyc(1); tick_en = 1'b0;
    expect_reg("R5 second reload", 2'd0, 32'd4);
    expect_reg("R5 second flag", 2'd3, FLAG);
    wr(2'd3, FLAG);
    wr(2'd2, 32'h0);
  endtask

  task automatic t_prio;
    wr(2'd0, 32'd20);
    tick_en = 1'b1; wr(2'd0, 32'd50); tick_en = 1'b0;
    expect_reg("R8 write beats tick", 2'd0, 32'd50);
  endtask

  task automatic t_readback;
    wr(2'd1, 32'hDEAD_BEEF);
    expect_reg("R9 reload readback", 2'd1, 32'hDEAD_BEEF);
    wr(2'd2, 32'h1234_5678 & ~IEN);
    expect_reg("R9 control readback", 2'd2, 32'h1234_5678 & ~IEN);
    expect_reg("R9 status unimplemented bits", 2'd3, 32'h0);
  endtask

  initial begin
    fork
      begin
        cyc(3); rst_n = 1'b1; cyc();
        t_reset(); t_hold(); t_count(); t_zero(); t_irq();
        t_w1c(); t_reload(); t_prio(); t_readback();
      end
      begin
        cyc(20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule